// File: doc/BRIEF.md
# Prioritized Instruction Address Sequencer

This block holds the address of the instruction a small processor fetches next. It is a 10-bit register that loads a new value on every rising clock edge. The new value comes from exactly one of six sources, chosen by a fixed priority. From highest to lowest they are: a serial test shift, a hold for pipeline hazards, a PC-relative branch with a signed 8-bit offset, a register-indirect jump, a call that also supplies a return address, and a plain step to the next address. All address arithmetic wraps modulo 1024.

The core holds the register. Its surrounding logic picks one source and computes the next value. The port `link_addr` always shows the current address plus one, so the register file can capture it as the return address when a call is taken. When `shift_en` is high, the register acts as a scan chain segment. Test data enters at bit 0 and leaves from bit 9 on `shift_out`. Hazard detection, instruction memory, the register file and the link register are outside this block.

Internally, the chosen source is an enumerated selector with six named values: SRC_SHIFT, SRC_HOLD, SRC_BRANCH, SRC_JUMP, SRC_CALL and SRC_STEP. The arbiter picks one of them on every cycle. Every value can follow every other, and reset forces the register to zero.

Top module: `instr_addr_seq`

## Requirements
- R1: Reset is synchronous and active high. A clock edge with `rst` high sets `addr_q` to 0x000, even when `shift_en` or any other control is high.
- R2: With no control high, each edge advances `addr_q` by one modulo 1024, so 0x3FF is followed by 0x000.
- R3: With `br_take` high and no higher-priority control, the next address is `addr_q` plus `br_ofs` read as a two's-complement 8-bit value and sign-extended, modulo 1024. For example, 0x020 with offset 0xFC gives 0x01C.
- R4: With `jmp_take` high and no higher-priority control, the next address is `tgt_reg[9:0]`. Bits above bit 9 are ignored.
- R5: With `call_take` high and no higher-priority control, the next address is `tgt_reg[9:0]`, and in that cycle `link_addr` shows the old address plus one.
- R6: While `hold` is high and `shift_en` is low, `addr_q` keeps its value. Stepping resumes on the first edge after `hold` falls.
- R7: With `shift_en` high, each edge loads `addr_q` with {`addr_q[8:0]`, `shift_in`}. `shift_out` always equals `addr_q[9]`.
- R8: The priority from highest to lowest is `shift_en`, `hold`, `br_take`, `jmp_take`, `call_take`, then step. Only the highest active source affects the next address.
- R9: `link_addr` always equals `addr_q` plus one modulo 1024, whichever source is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| br_take | input | 1 | Take PC-relative branch |
| jmp_take | input | 1 | Take register-indirect jump |
| call_take | input | 1 | Take call to register target |
| hold | input | 1 | Freeze the address |
| br_ofs | input | 8 | Signed branch offset |
| tgt_reg | input | 16 | Register operand; low 10 bits are the target |
| shift_en | input | 1 | Scan shift mode |
| shift_in | input | 1 | Scan serial input into bit 0 |
| addr_q | output | 10 | Current instruction address |
| link_addr | output | 10 | Current address plus one (return address) |
| shift_out | output | 1 | Scan serial output, bit 9 |

## Verification
The bench sweeps every one of the 256 offsets from several base addresses, including addresses near 0 and near 0x3FF. This exposes a design that zero-extends the offset: it would jump forward by about 256 where a negative offset should move backward. It would also expose a design that fails to wrap the sum across the top of the address range. It steps through all 1024 addresses so that the 0x3FF to 0x000 rollover is seen, and it loads every target value with noise in the unused upper operand bits, which catches a target taken from the wrong bits. It drives all 32 combinations of the five controls, which catches a priority inversion such as hold taking effect over shift. It also asserts reset together with shift, to catch a reset that loses to scan.

// File: rtl/ias_pkg.sv
package ias_pkg;

    // Source selected for the next instruction address, highest priority first.
    typedef enum logic [2:0] {
        SRC_SHIFT  = 3'd0,
        SRC_HOLD   = 3'd1,
        SRC_BRANCH = 3'd2,
        SRC_JUMP   = 3'd3,
        SRC_CALL   = 3'd4,
        SRC_STEP   = 3'd5
    } src_e;

endpackage

// File: rtl/ias_src_arbiter.sv
module ias_src_arbiter
    import ias_pkg::*;
(
    input  logic shift_en,
    input  logic hold,
    input  logic br_take,
    input  logic jmp_take,
    input  logic call_take,
    output src_e src
);

    // Fixed priority: the first active request wins.
    always_comb begin
        if (shift_en)       src = SRC_SHIFT;
        else if (hold)      src = SRC_HOLD;
        else if (br_take)   src = SRC_BRANCH;
        else if (jmp_take)  src = SRC_JUMP;
        else if (call_take) src = SRC_CALL;
        else                src = SRC_STEP;
    end

endmodule

// File: rtl/ias_next_addr.sv
module ias_next_addr
    import ias_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int OFS_W  = 8
) (
    input  src_e              src,
    input  logic [ADDR_W-1:0] cur,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [ADDR_W-1:0] tgt,
    input  logic              shift_in,
    output logic [ADDR_W-1:0] nxt,
    output logic [ADDR_W-1:0] inc
);

    localparam int EXT_W = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] ofs_ext;
    logic [ADDR_W-1:0] br_sum;

    // Sign-extend the offset to the address width, or truncate it when it is wider.
    generate
        if (EXT_W > 0) begin : g_ext
            assign ofs_ext = {{EXT_W{ofs[OFS_W-1]}}, ofs};
        end else begin : g_trunc
            assign ofs_ext = ofs[ADDR_W-1:0];
        end
    endgenerate

    assign inc    = cur + ADDR_W'(1);
    assign br_sum = cur + ofs_ext;

    always_comb begin
        unique case (src)
            SRC_SHIFT:  nxt = {cur[ADDR_W-2:0], shift_in};
            SRC_HOLD:   nxt = cur;
            SRC_BRANCH: nxt = br_sum;
            SRC_JUMP:   nxt = tgt;
            SRC_CALL:   nxt = tgt;
            SRC_STEP:   nxt = inc;
            default:    nxt = inc;
        endcase
    end

endmodule

// File: rtl/instr_addr_seq.sv
module instr_addr_seq
    import ias_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int OFS_W  = 8,
    parameter int OPND_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              br_take,
    input  logic              jmp_take,
    input  logic              call_take,
    input  logic              hold,
    input  logic [OFS_W-1:0]  br_ofs,
    input  logic [OPND_W-1:0] tgt_reg,
    input  logic              shift_en,
    input  logic              shift_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [ADDR_W-1:0] link_addr,
    output logic              shift_out
);

    src_e              src;
    logic [ADDR_W-1:0] nxt;
    logic [ADDR_W-1:0] tgt_lo;

    // Only the low address bits of the operand form the target.
    generate
        if (OPND_W > ADDR_W) begin : g_wide_opnd
            logic unused_opnd_hi;
            assign unused_opnd_hi = ^tgt_reg[OPND_W-1:ADDR_W];
            assign tgt_lo         = tgt_reg[ADDR_W-1:0];
        end else begin : g_narrow_opnd
            assign tgt_lo = ADDR_W'(tgt_reg);
        end
    endgenerate

    ias_src_arbiter u_arb (
        .shift_en  (shift_en),
        .hold      (hold),
        .br_take   (br_take),
        .jmp_take  (jmp_take),
        .call_take (call_take),
        .src       (src)
    );

    ias_next_addr #(
        .ADDR_W (ADDR_W),
        .OFS_W  (OFS_W)
    ) u_nxt (
        .src      (src),
        .cur      (addr_q),
        .ofs      (br_ofs),
        .tgt      (tgt_lo),
        .shift_in (shift_in),
        .nxt      (nxt),
        .inc      (link_addr)
    );

    // Address register; reset wins over every source.
    always_ff @(posedge clk) begin
        if (rst) addr_q <= '0;
        else     addr_q <= nxt;
    end

    assign shift_out = addr_q[ADDR_W-1];

endmodule

// File: rtl/ias_checker.sv
module ias_checker #(
    parameter int ADDR_W = 10,
    parameter int OFS_W  = 8,
    parameter int OPND_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              br_take,
    input logic              jmp_take,
    input logic              call_take,
    input logic              hold,
    input logic [OFS_W-1:0]  br_ofs,
    input logic [OPND_W-1:0] tgt_reg,
    input logic              shift_en,
    input logic              shift_in,
    input logic [ADDR_W-1:0] addr_q,
    input logic [ADDR_W-1:0] link_addr,
    input logic              shift_out
);

    logic [ADDR_W-1:0] ofs_wide;
    assign ofs_wide = ADDR_W'($signed(br_ofs));

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> addr_q == '0);

    p_step_from_link_r2: assert property (@(posedge clk) disable iff (rst)
        !(shift_en || hold || br_take || jmp_take || call_take)
        |=> addr_q == $past(link_addr));

    p_branch_sum_r3: assert property (@(posedge clk) disable iff (rst)
        (br_take && !shift_en && !hold)
        |=> addr_q == ADDR_W'($past(addr_q) + $past(ofs_wide)));

    p_jump_target_r4: assert property (@(posedge clk) disable iff (rst)
        (jmp_take && !br_take && !shift_en && !hold)
        |=> addr_q == $past(tgt_reg[ADDR_W-1:0]));

    p_call_target_r5: assert property (@(posedge clk) disable iff (rst)
        (call_take && !jmp_take && !br_take && !shift_en && !hold)
        |=> addr_q == $past(tgt_reg[ADDR_W-1:0]));

    p_hold_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        (hold && !shift_en) |=> $stable(addr_q));

    p_shift_chain_r7: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> addr_q == {$past(addr_q[ADDR_W-2:0]), $past(shift_in)});

    p_shift_out_r7: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> shift_out == $past(addr_q[ADDR_W-2]));

endmodule

bind instr_addr_seq ias_checker #(
    .ADDR_W (ADDR_W),
    .OFS_W  (OFS_W),
    .OPND_W (OPND_W)
) u_ias_checker (
    .clk       (clk),
    .rst       (rst),
    .br_take   (br_take),
    .jmp_take  (jmp_take),
    .call_take (call_take),
    .hold      (hold),
    .br_ofs    (br_ofs),
    .tgt_reg   (tgt_reg),
    .shift_en  (shift_en),
    .shift_in  (shift_in),
    .addr_q    (addr_q),
    .link_addr (link_addr),
    .shift_out (shift_out)
);

// File: tb/test_instr_addr_seq.sv
`timescale 1ns/1ps
module test_instr_addr_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        br_take = 1'b0, jmp_take = 1'b0, call_take = 1'b0, hold = 1'b0;
    logic [7:0]  br_ofs = '0;
    logic [15:0] tgt_reg = '0;
    logic        shift_en = 1'b0, shift_in = 1'b0;
    logic [9:0]  addr_q, link_addr;
    logic        shift_out;

    int tests = 0;
    int fails = 0;
    logic [9:0] model = '0;

    always #2.5 clk = ~clk;

    instr_addr_seq i_instr_addr_seq (
        .clk(clk), .rst(rst), .br_take(br_take), .jmp_take(jmp_take),
        .call_take(call_take), .hold(hold), .br_ofs(br_ofs), .tgt_reg(tgt_reg),
        .shift_en(shift_en), .shift_in(shift_in), .addr_q(addr_q),
        .link_addr(link_addr), .shift_out(shift_out)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Drive one cycle of controls, check link before the edge and the address after it.
    task automatic cyc(input logic r, input logic se, input logic si, input logic hd,
                       input logic br, input logic jp, input logic cl,
                       input logic [7:0] ofs, input logic [15:0] tgt, input string req);
        logic [9:0] exp;
        @(negedge clk);
        rst = r; shift_en = se; shift_in = si; hold = hd;
        br_take = br; jmp_take = jp; call_take = cl; br_ofs = ofs; tgt_reg = tgt;
        if (r)        exp = '0;
        else if (se)  exp = {model[8:0], si};
        else if (hd)  exp = model;
        else if (br)  exp = model + {{2{ofs[7]}}, ofs};
        else if (jp)  exp = tgt[9:0];
        else if (cl)  exp = tgt[9:0];
        else          exp = model + 10'd1;
        #1;
        if (!r) check("R9 link", 16'(link_addr), 16'(10'(model + 10'd1)));
        @(posedge clk);
        #1;
        model = exp;
        check(req, 16'(addr_q), 16'(exp));
        check("R7 shift_out", 16'(shift_out), 16'(exp[9]));
    endtask

    task automatic idle(input string req);
        cyc(0, 0, 0, 0, 0, 0, 0, 8'h00, 16'h0, req);
    endtask

    task automatic go_to(input logic [9:0] a);
        cyc(0, 0, 0, 0, 0, 1, 0, 8'h00, {6'h2A, a}, "R4 load");
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1 reset state, including reset over shift
        cyc(1, 0, 0, 0, 0, 0, 0, 8'h00, 16'h0, "R1 reset");
        check("R1 link after reset", 16'(link_addr), 16'h001);
        // R2 full sweep including wrap at 0x3FF
        for (int i = 0; i < 1030; i++) idle("R2 step");
        go_to(10'h155);
        cyc(1, 1, 1, 1, 1, 1, 1, 8'hFF, 16'hFFFF, "R1 reset beats shift");

        // R3 every offset from several bases
        for (int b = 0; b < 4; b++) begin
            logic [9:0] base;
            base = (b == 0) ? 10'h000 : (b == 1) ? 10'h020 : (b == 2) ? 10'h3FF : 10'h205;
            for (int o = 0; o < 256; o++) begin
                go_to(base);
                cyc(0, 0, 0, 0, 1, 0, 0, 8'(o), 16'h0, "R3 branch");
            end
        end
        go_to(10'h020);
        cyc(0, 0, 0, 0, 1, 0, 0, 8'hFC, 16'h0, "R3 example 0x01C");

        // R4 / R5 every target with noisy upper operand bits
        for (int t = 0; t < 1024; t++) begin
            cyc(0, 0, 0, 0, 0, 1, 0, 8'h00, {6'(t * 7 + 3), 10'(t)}, "R4 jump");
        end
        go_to(10'h040);
        cyc(0, 0, 0, 0, 0, 0, 1, 8'h00, 16'hFE00 | 16'h200, "R5 call");
        for (int t = 0; t < 64; t++)
            cyc(0, 0, 0, 0, 0, 0, 1, 8'h00, {6'(t), 10'(t * 16 + 5)}, "R5 call sweep");

        // R6 hold and resume
        go_to(10'h050);
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 0, 0, 0, 8'h00, 16'h0, "R6 hold");
        idle("R6 resume");

        // R7 shift a pattern through the chain and watch it leave
        for (int k = 0; k < 30; k++)
            cyc(0, 1, 1'((k * 5 + 1) % 3 == 0), 0, 0, 0, 0, 8'h00, 16'h0, "R7 shift");

        // R8 all control combinations from several addresses
        for (int a = 0; a < 3; a++) begin
            for (int m = 0; m < 32; m++) begin
                for (int si = 0; si < 2; si++) begin
                    go_to(10'(a * 341 + 17));
                    cyc(0, m[4], 1'(si), m[3], m[2], m[1], m[0], 8'h83, 16'hC1E7, "R8 priority");
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule